// File: doc/BRIEF.md
# Signed/Unsigned Iterative Integer Divider

This block divides one W-bit integer by another and returns both quotient and remainder. A mode input picks unsigned or two's complement operation. In signed mode the operands are turned into magnitudes and passed to an unsigned iterative core. The core settles LOG2_RADIX quotient bits per clock. When the core finishes, the sign of each result is corrected.

Division by zero and the one overflowing signed case (the most negative value divided by minus one) give fixed results rather than undefined ones. The remainder always carries the sign of the dividend. The caller pulses `start` with the operands while `busy` is low. `done` then pulses for one cycle with the results valid. The results stay on the outputs until the next accepted start.

Top module: `sud_divider`

## Requirements
- R1: With `is_signed` = 0 and a non-zero divisor, `quotient` equals the truncating unsigned quotient and `remainder` the unsigned modulo.
- R2: With `is_signed` = 1 and a non-zero divisor, `quotient` is |dividend| / |divisor| rounded toward zero. It is negated (two's complement, W bits) when the operand signs (bit W-1) differ.
- R3: With `is_signed` = 1 and a non-zero divisor, `remainder` has magnitude |dividend| mod |divisor| and is negated when the dividend is negative, so a non-zero remainder has the dividend's sign.
- R4: A divisor of zero gives `quotient` all ones and `remainder` equal to the original dividend, in both modes.
- R5: In signed mode, dividend 2^(W-1) (most negative) divided by all-ones (-1) gives `quotient` equal to the most negative value and `remainder` 0. The magnitude of the most negative value is taken as the unsigned number 2^(W-1).
- R6: A start is accepted when `start` is high and `busy` is low at a rising edge. `busy` is high from the next cycle. `done` is high for exactly one cycle, ceil(W/LOG2_RADIX) cycles after the accepting edge, and `busy` falls in that same cycle.
- R7: `start` while `busy` is high is ignored. Operands and mode are sampled only at the accepting edge, so later changes do not alter the result, and no second operation follows.
- R8: After `done`, `quotient` and `remainder` hold their values until the next accepted start, whatever the other inputs do.
- R9: After synchronous reset, `busy`, `done`, `quotient` and `remainder` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division; accepted when busy is low |
| is_signed | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend | input | W | Numerator |
| divisor | input | W | Denominator |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse, results valid |
| quotient | output | W | Quotient, held after done |
| remainder | output | W | Remainder, held after done |

## Verification
The assertions assume that every input is a known value at each rising edge and that reset is applied before the first start. They also assume that LOG2_RADIX lies between 1 and W, so every step retires at least one quotient bit. The bench drives all inputs from defined values on falling edges, starting from reset. It sweeps every operand pair at W = 4 in both modes for radix exponents 1 to 4. During each run it injects a deliberately conflicting start with different operands while the block is busy, and it changes the operands while the results are held.

// File: rtl/sud_pkg.sv
package sud_pkg;

    typedef enum logic {
        DV_IDLE = 1'b0,
        DV_RUN  = 1'b1
    } dv_state_e;

    // sign corrections captured when an operation is accepted
    typedef struct packed {
        logic neg_quo;
        logic neg_rem;
    } dv_fix_t;

    function automatic int unsigned dv_steps(int unsigned w, int unsigned k);
        return (w + k - 1) / k;
    endfunction

endpackage

// File: rtl/sud_prep.sv
module sud_prep
    import sud_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] num_mag,
    output logic [W-1:0] den_mag,
    output dv_fix_t      fix
);
    logic n_neg, d_neg, d_zero;

    always_comb begin
        n_neg  = is_signed & dividend[W-1];
        d_neg  = is_signed & divisor[W-1];
        d_zero = (divisor == '0);
        // two's complement negate of the most negative value yields 2^(W-1)
        // read as unsigned, which is its true magnitude
        num_mag = n_neg ? (~dividend + W'(1)) : dividend;
        den_mag = d_neg ? (~divisor + W'(1)) : divisor;
        fix.neg_quo = (n_neg ^ d_neg) & ~d_zero;
        fix.neg_rem = n_neg;
    end
endmodule

// File: rtl/sud_core.sv
module sud_core
    import sud_pkg::*;
#(
    parameter int W          = 32,
    parameter int LOG2_RADIX = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] num_mag,
    input  logic [W-1:0] den_mag,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo_mag,
    output logic [W-1:0] rem_mag
);
    localparam int K      = LOG2_RADIX;
    localparam int RADIX  = 1 << K;
    localparam int EW     = 2 * W + K + 1;
    localparam int SW     = $clog2(W + 1);
    localparam int NSTEP  = dv_steps(W, K);
    localparam int CW     = $clog2(NSTEP + 1);

    dv_state_e       st;
    logic [SW-1:0]   shift;
    logic [SW-1:0]   step_bits;
    logic [SW-1:0]   new_sh;
    logic [W-1:0]    dvs;
    logic [W-1:0]    q_r;
    logic [W-1:0]    r_r;
    logic [K-1:0]    sel;
    logic [W+K-1:0]  qadd;
    logic [EW-1:0]   cand [RADIX];
    int              lim;

    assign busy    = (st == DV_RUN);
    assign quo_mag = q_r;
    assign rem_mag = r_r;

    always_comb begin
        step_bits = (shift < SW'(K)) ? shift : SW'(K);
        new_sh    = shift - step_bits;
        lim       = 1 << step_bits;
    end

    // one trial subtraction per candidate digit
    for (genvar gi = 0; gi < RADIX; gi++) begin : g_cand
        assign cand[gi] = EW'(r_r) - ((EW'(gi) * EW'(dvs)) << new_sh);
    end

    // largest digit whose trial remainder stays non-negative
    always_comb begin
        sel = '0;
        for (int i = 0; i < RADIX; i++) begin
            if (!cand[i][EW-1] && (i < lim)) sel = K'(i);
        end
        qadd = (W + K)'(sel) << new_sh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= DV_IDLE;
            shift <= '0;
            dvs   <= '0;
            q_r   <= '0;
            r_r   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                DV_IDLE: begin
                    if (start) begin
                        dvs   <= den_mag;
                        r_r   <= num_mag;
                        q_r   <= '0;
                        shift <= SW'(W);
                        st    <= DV_RUN;
                    end
                end
                DV_RUN: begin
                    r_r   <= cand[sel][W-1:0];
                    q_r   <= q_r | qadd[W-1:0];
                    shift <= new_sh;
                    if (new_sh == '0) begin
                        st   <= DV_IDLE;
                        done <= 1'b1;
                    end
                end
                default: st <= DV_IDLE;
            endcase
        end
    end

    // cycle counter used only by the latency check
    logic [CW-1:0] run_cnt;
    always_ff @(posedge clk) begin
        if (rst)                 run_cnt <= '0;
        else if (start && !busy) run_cnt <= '0;
        else if (busy)           run_cnt <= run_cnt + CW'(1);
    end

    // R6: done only as the run ends, after exactly NSTEP busy cycles
    a_r6_done_ends_run: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy) && run_cnt == CW'(NSTEP)));

    // R6: an accepted start enters the busy state
    a_r6_start_enters_run: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R7: the divisor in use cannot change while busy
    a_r7_busy_keeps_divisor: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(dvs));

    // R8: results hold while idle without a start
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(q_r) && $stable(r_r)));
endmodule

// File: rtl/sud_fix.sv
module sud_fix
    import sud_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    input  dv_fix_t      fix,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    always_comb begin
        quotient  = fix.neg_quo ? (~quo_mag + W'(1)) : quo_mag;
        remainder = fix.neg_rem ? (~rem_mag + W'(1)) : rem_mag;
    end
endmodule

// File: rtl/sud_divider.sv
module sud_divider
    import sud_pkg::*;
#(
    parameter int W          = 32,
    parameter int LOG2_RADIX = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int DW = 2 * W;
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] num_mag, den_mag, quo_mag, rem_mag;
    dv_fix_t      fix_in, fix_q;
    logic         accept;

    // operand copies kept for the result checks below
    logic [W-1:0] n_h, d_h;
    logic         s_h;

    assign accept = start && !busy;

    sud_prep #(.W(W)) u_prep (
        .is_signed (is_signed),
        .dividend  (dividend),
        .divisor   (divisor),
        .num_mag   (num_mag),
        .den_mag   (den_mag),
        .fix       (fix_in)
    );

    sud_core #(.W(W), .LOG2_RADIX(LOG2_RADIX)) u_core (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .num_mag (num_mag),
        .den_mag (den_mag),
        .busy    (busy),
        .done    (done),
        .quo_mag (quo_mag),
        .rem_mag (rem_mag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fix_q <= '0;
            n_h   <= '0;
            d_h   <= '0;
            s_h   <= 1'b0;
        end else if (accept) begin
            fix_q <= fix_in;
            n_h   <= dividend;
            d_h   <= divisor;
            s_h   <= is_signed;
        end
    end

    sud_fix #(.W(W)) u_fix (
        .quo_mag   (quo_mag),
        .rem_mag   (rem_mag),
        .fix       (fix_q),
        .quotient  (quotient),
        .remainder (remainder)
    );

    // R1: unsigned results reconstruct the dividend with a smaller remainder
    a_r1_unsigned_identity: assert property (@(posedge clk) disable iff (rst)
        (done && !s_h && d_h != '0) |->
        ((DW'(quotient) * DW'(d_h) + DW'(remainder) == DW'(n_h)) && (remainder < d_h)));

    // R2: a non-zero signed quotient carries the xor of the operand signs
    a_r2_quo_sign: assert property (@(posedge clk) disable iff (rst)
        (done && s_h && d_h != '0 && quotient != '0 && !(n_h == MOST_NEG && d_h == '1)) |->
        (quotient[W-1] == (n_h[W-1] ^ d_h[W-1])));

    // R3: a non-zero signed remainder takes the dividend's sign
    a_r3_rem_sign: assert property (@(posedge clk) disable iff (rst)
        (done && s_h && remainder != '0) |-> (remainder[W-1] == n_h[W-1]));

    // R4: zero divisor gives all ones and the dividend back
    a_r4_zero_divisor: assert property (@(posedge clk) disable iff (rst)
        (done && d_h == '0) |-> (quotient == '1 && remainder == n_h));

    // R5: the single signed overflow wraps
    a_r5_no_overflow_trap: assert property (@(posedge clk) disable iff (rst)
        (done && s_h && n_h == MOST_NEG && d_h == '1) |->
        (quotient == MOST_NEG && remainder == '0));
endmodule

// File: tb/tb_sud_divider.sv
module tb_sud_divider;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int finished = 0;
    bit reported = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected {quotient, remainder} from plain integer arithmetic
    function automatic logic [2*W-1:0] model(input logic [W-1:0] n, input logic [W-1:0] d,
                                             input logic s);
        int ni, di, qi, ri;
        if (s) begin
            ni = int'($signed(n));
            di = int'($signed(d));
        end else begin
            ni = int'(n);
            di = int'(d);
        end
        if (di == 0) begin
            qi = -1;
            ri = ni;
        end else if (s && ni == -(1 << (W - 1)) && di == -1) begin
            qi = ni;
            ri = 0;
        end else begin
            qi = ni / di;
            ri = ni % di;
        end
        return {qi[W-1:0], ri[W-1:0]};
    endfunction

    for (genvar gk = 1; gk <= 4; gk++) begin : g_rad
        localparam int NS = (W + gk - 1) / gk;

        logic         start = 1'b0;
        logic         sgn = 1'b0;
        logic [W-1:0] num = '0;
        logic [W-1:0] den = '0;
        logic         busy, done;
        logic [W-1:0] quo, rem;

        sud_divider #(.W(W), .LOG2_RADIX(gk)) dut (
            .clk       (clk),
            .rst       (rst),
            .start     (start),
            .is_signed (sgn),
            .dividend  (num),
            .divisor   (den),
            .busy      (busy),
            .done      (done),
            .quotient  (quo),
            .remainder (rem)
        );

        task automatic run_case(input logic [W-1:0] n, input logic [W-1:0] d, input logic s);
            logic [2*W-1:0] exp;
            logic [W-1:0]   q_seen, r_seen;
            string          qreq, rreq;
            int             cyc;
            exp = model(n, d, s);
            if (d == '0)                                        begin qreq = "R4"; rreq = "R4"; end
            else if (!s)                                        begin qreq = "R1"; rreq = "R1"; end
            else if (n == {1'b1, {(W-1){1'b0}}} && d == '1)     begin qreq = "R5"; rreq = "R5"; end
            else                                                begin qreq = "R2"; rreq = "R3"; end

            @(negedge clk);
            num = n; den = d; sgn = s; start = 1'b1;
            @(negedge clk);
            chk(busy == 1'b1, "R6 busy after accept", int'(busy), 1);
            // R7: conflicting request while busy must be ignored
            num = ~n; den = d + W'(1); sgn = ~s; start = 1'b1;
            cyc = 0;
            do begin
                @(negedge clk);
                start = 1'b0;
                cyc++;
            end while (!done && cyc < 40);
            chk(cyc == NS, "R6 done latency", cyc, NS);
            chk(quo == exp[2*W-1:W], qreq, int'(quo), int'(exp[2*W-1:W]));
            chk(rem == exp[W-1:0], rreq, int'(rem), int'(exp[W-1:0]));
            q_seen = quo; r_seen = rem;
            // R8: operand changes without start have no effect
            num = n ^ W'(5); den = d ^ W'(3); sgn = ~s;
            @(negedge clk);
            chk(done == 1'b0 && busy == 1'b0, "R7 no second operation",
                int'({busy, done}), 0);
            @(negedge clk);
            chk(quo == q_seen, "R8 quotient held", int'(quo), int'(q_seen));
            chk(rem == r_seen, "R8 remainder held", int'(rem), int'(r_seen));
        endtask

        initial begin
            wait (rst == 1'b0);
            @(negedge clk);
            chk(busy == 1'b0 && done == 1'b0, "R9 reset flags", int'({busy, done}), 0);
            chk(quo == '0 && rem == '0, "R9 reset results", int'({quo, rem}), 0);
            for (int s = 0; s < 2; s++) begin
                for (int n = 0; n < (1 << W); n++) begin
                    for (int d = 0; d < (1 << W); d++) begin
                        run_case(W'(n), W'(d), s[0]);
                    end
                end
            end
            finished++;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        wait (finished == 4);
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!reported) begin
            reported = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL R6 watchdog: actual=%0d expected=%0d finished sweeps", finished, 4);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule